// File: doc/BRIEF.md
# Row-Diagonal Dual-Parity Stripe Codec

This block holds one stripe of a dual-parity storage array built around a prime `P`. The stripe has `P+1` columns of `P-1` words each, `W` bits per word. Columns `0` to `P-2` carry data. Column `P-1` carries the row parity: the XOR of the data words in each row. Column `P` carries the diagonal parity. A word at row `r` and column `c` (with `c` up to `P-1`) lies on diagonal `(r+c) mod P`. Diagonal parity word `d` is the XOR of every word on diagonal `d`, and that includes the row-parity words. Only diagonals `0` to `P-2` are kept. Diagonal `P-1` has no stored word.

Software fills the stripe one word at a time through a write port and reads it back through a combinational read port. A start pulse launches one of two operations. Encode produces both parity columns. Recover takes a mask of lost columns and rebuilds every lost word. Both operations run on one engine, which rebuilds one word per clock. In each cycle it searches the row equations and the diagonal equations for one that has exactly one unknown word. Diagonal equations are searched first. When two data columns are lost, the engine therefore moves back and forth between diagonal fixes and row fixes until the stripe is whole again.

Top module: `rdp_codec`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and every word of the stripe reads as zero.
- R2: Encode is selected with `op`=0. Word `r` of column `P-1` becomes the XOR of the data words in row `r`. Word `d` of column `P` (for `d` < `P-1`) becomes the XOR of every word in columns `0..P-1` whose (row+column) mod `P` equals `d`. The data columns keep their values, and `fail_mask` has no effect.
- R3: After an encode start is taken, `busy` is high for exactly `2(P-1)+1` cycles. On the next edge `busy` falls and `done` rises.
- R4: Recover is selected with `op`=1. Bit `c` of `fail_mask` marks column `c` as lost. Columns `0..P-2` are data, `P-1` is row parity and `P` is diagonal parity. When one data column is marked, every one of its words is restored.
- R5: When any two data columns are marked, all words of both columns are restored.
- R6: When the marked columns include one or both parity columns, every marked word is restored.
- R7: When `k` columns are marked (k ≤ 2), `busy` is high for exactly `k(P-1)+1` cycles and then `done` rises. With `k`=0 this is one cycle.
- R8: When more than two columns are marked, `err` rises on the edge that takes the start, `busy` stays low and no word changes.
- R9: While `busy` is high, `wr_en` and `start` are ignored.
- R10: `done` and `err` hold their value until the next start is taken, and that edge clears them. The two are never high together, and neither is high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when idle |
| op | input | 1 | 0 = encode, 1 = recover |
| fail_mask | input | P+1 | One bit per lost column (recover only) |
| wr_en | input | 1 | Host word write, idle only |
| wr_col | input | $clog2(P+1) | Column of the host write |
| wr_row | input | $clog2(P-1) | Row of the host write |
| wr_data | input | W | Word to write |
| rd_col | input | $clog2(P+1) | Column to read |
| rd_row | input | $clog2(P-1) | Row to read |
| rd_data | output | W | Word at (rd_col, rd_row), combinational |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed |
| err | output | 1 | Last operation rejected or stalled |

## Verification
The internal state that matters is the mask of unknown words. Suppose one of its bits is set or cleared wrongly. The run then has the wrong length, so `done` rises a cycle early or late, or `err` rises. Either way the port flags differ from the expected cycle count as soon as the operation ends. A wrong diagonal membership or a wrong row index in the rebuild path instead produces a wrong word, and that word shows up in the full-stripe readback after `done`. The bench checks every data and parity word after each encode, and after recovery of every single-column and every two-column loss.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [0:0] {
        OP_ENCODE  = 1'b0,
        OP_RECOVER = 1'b1
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // Row on which diagonal d crosses column c (c < p); equal to p-1 means no row.
    function automatic int diag_row(input int d, input int c, input int p);
        return (d + p - c) % p;
    endfunction

endpackage

// File: rtl/rdp_store.sv
module rdp_store #(
    parameter int P = 5,
    parameter int W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           host_we,
    input  logic [$clog2(P+1)-1:0]         host_col,
    input  logic [$clog2(P-1)-1:0]         host_row,
    input  logic [W-1:0]                   host_data,
    input  logic                           fix_we,
    input  logic [$clog2(P+1)-1:0]         fix_col,
    input  logic [$clog2(P-1)-1:0]         fix_row,
    input  logic [W-1:0]                   fix_data,
    input  logic [$clog2(P+1)-1:0]         rd_col,
    input  logic [$clog2(P-1)-1:0]         rd_row,
    output logic [W-1:0]                   rd_data,
    output logic [P:0][P-2:0][W-1:0]       words
);
    localparam int NC = P + 1;
    localparam int NR = P - 1;
    localparam int CW = $clog2(NC);
    localparam int RW = $clog2(NR);
    localparam logic [CW:0] COL_LIM = (CW+1)'(NC);
    localparam logic [RW:0] ROW_LIM = (RW+1)'(NR);

    logic host_ok;
    logic rd_ok;

    assign host_ok = ({1'b0, host_col} < COL_LIM) && ({1'b0, host_row} < ROW_LIM);
    assign rd_ok   = ({1'b0, rd_col} < COL_LIM) && ({1'b0, rd_row} < ROW_LIM);
    assign rd_data = rd_ok ? words[rd_col][rd_row] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (fix_we) begin
            words[fix_col][fix_row] <= fix_data;
        end else if (host_we && host_ok) begin
            words[host_col][host_row] <= host_data;
        end
    end

endmodule

// File: rtl/rdp_eqn.sv
module rdp_eqn
    import rdp_pkg::*;
#(
    parameter int P = 5,
    parameter int W = 8
) (
    input  logic [P:0][P-2:0][W-1:0]   words,
    input  logic [P:0][P-2:0]          miss,
    output logic                       fix_ok,
    output logic [$clog2(P+1)-1:0]     fix_col,
    output logic [$clog2(P-1)-1:0]     fix_row,
    output logic [W-1:0]               fix_val
);
    localparam int NC = P + 1;
    localparam int NR = P - 1;
    localparam int NE = 2 * NR;          // diagonals 0..NR-1, then rows 0..NR-1
    localparam int CW = $clog2(NC);
    localparam int RW = $clog2(NR);
    localparam logic [CW:0] CNT_ONE = 1;

    logic [NE-1:0]         eq_ok;
    logic [NE-1:0][CW-1:0] eq_col;
    logic [NE-1:0][RW-1:0] eq_row;
    logic [NE-1:0][W-1:0]  eq_val;

    for (genvar e = 0; e < NE; e++) begin : g_eq
        logic [P:0]         m_in;
        logic [P:0]         m_gone;
        logic [P:0][W-1:0]  m_word;
        logic [P:0][RW-1:0] m_row;
        logic [W-1:0]       acc;
        logic [CW:0]        cnt;
        logic [CW-1:0]      pick_c;
        logic [RW-1:0]      pick_r;

        // slot s is column s; slot P is the stored diagonal word
        for (genvar s = 0; s <= P; s++) begin : g_slot
            localparam int SR = (s == P) ? e : ((e < NR) ? diag_row(e, s, P) : (e - NR));
            localparam bit ON = (s == P) ? (e < NR) : (SR < NR);
            if (ON) begin : g_on
                assign m_in[s]   = 1'b1;
                assign m_gone[s] = miss[s][SR];
                assign m_word[s] = words[s][SR];
                assign m_row[s]  = RW'(SR);
            end else begin : g_off
                assign m_in[s]   = 1'b0;
                assign m_gone[s] = 1'b0;
                assign m_word[s] = '0;
                assign m_row[s]  = '0;
            end
        end

        always_comb begin
            acc    = '0;
            cnt    = '0;
            pick_c = '0;
            pick_r = '0;
            for (int s = 0; s <= P; s++) begin
                if (m_gone[s]) begin
                    cnt    = cnt + CNT_ONE;
                    pick_c = CW'(s);
                    pick_r = m_row[s];
                end else if (m_in[s]) begin
                    acc = acc ^ m_word[s];
                end
            end
        end

        assign eq_ok[e]  = (cnt == CNT_ONE);
        assign eq_col[e] = pick_c;
        assign eq_row[e] = pick_r;
        assign eq_val[e] = acc;
    end

    // lowest equation index wins: diagonal equations before row equations
    always_comb begin
        fix_ok  = 1'b0;
        fix_col = '0;
        fix_row = '0;
        fix_val = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (eq_ok[e]) begin
                fix_ok  = 1'b1;
                fix_col = eq_col[e];
                fix_row = eq_row[e];
                fix_val = eq_val[e];
            end
        end
    end

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
#(
    parameter int P = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  op_e                        op,
    input  logic [P:0]                 fail_mask,
    input  logic                       fix_ok,
    input  logic [$clog2(P+1)-1:0]     fix_col,
    input  logic [$clog2(P-1)-1:0]     fix_row,
    output logic [P:0][P-2:0]          miss,
    output logic                       fix_we,
    output logic                       busy,
    output logic                       done,
    output logic                       err
);
    localparam int NC = P + 1;
    localparam int NR = P - 1;
    localparam int CW = $clog2(NC);
    localparam logic [NC-1:0] PAR_MASK = {2'b11, {(NC-2){1'b0}}};
    localparam logic [CW:0]   MAX_LOST = 2;

    state_e        st;
    logic [NC-1:0] eff;
    logic [CW:0]   nlost;
    logic          any_miss;

    always_comb begin
        eff   = (op == OP_ENCODE) ? PAR_MASK : fail_mask;
        nlost = '0;
        for (int c = 0; c < NC; c++) begin
            nlost = nlost + {{CW{1'b0}}, eff[c]};
        end
    end

    assign any_miss = |miss;
    assign busy     = (st == ST_RUN);
    assign fix_we   = busy && any_miss && fix_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            miss <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        done <= 1'b0;
                        err  <= (nlost > MAX_LOST);
                        if (nlost <= MAX_LOST) begin
                            st <= ST_RUN;
                            for (int c = 0; c < NC; c++) begin
                                miss[c] <= {NR{eff[c]}};
                            end
                        end
                    end
                end
                ST_RUN: begin
                    if (!any_miss) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else if (fix_ok) begin
                        miss[fix_col][fix_row] <= 1'b0;
                    end else begin
                        err <= 1'b1;
                        st  <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rdp_codec.sv
module rdp_codec
    import rdp_pkg::*;
#(
    parameter int P = 5,
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       op,
    input  logic [P:0]                 fail_mask,
    input  logic                       wr_en,
    input  logic [$clog2(P+1)-1:0]     wr_col,
    input  logic [$clog2(P-1)-1:0]     wr_row,
    input  logic [W-1:0]               wr_data,
    input  logic [$clog2(P+1)-1:0]     rd_col,
    input  logic [$clog2(P-1)-1:0]     rd_row,
    output logic [W-1:0]               rd_data,
    output logic                       busy,
    output logic                       done,
    output logic                       err
);
    localparam int CW = $clog2(P + 1);
    localparam int RW = $clog2(P - 1);

    logic [P:0][P-2:0][W-1:0] words;
    logic [P:0][P-2:0]        miss;
    logic                     fix_ok;
    logic                     fix_we;
    logic [CW-1:0]            fix_col;
    logic [RW-1:0]            fix_row;
    logic [W-1:0]             fix_val;
    logic                     host_we;
    op_e                      op_sel;

    assign host_we = wr_en && !busy;
    assign op_sel  = op ? OP_RECOVER : OP_ENCODE;

    rdp_store #(.P(P), .W(W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_col  (wr_col),
        .host_row  (wr_row),
        .host_data (wr_data),
        .fix_we    (fix_we),
        .fix_col   (fix_col),
        .fix_row   (fix_row),
        .fix_data  (fix_val),
        .rd_col    (rd_col),
        .rd_row    (rd_row),
        .rd_data   (rd_data),
        .words     (words)
    );

    rdp_eqn #(.P(P), .W(W)) u_eqn (
        .words   (words),
        .miss    (miss),
        .fix_ok  (fix_ok),
        .fix_col (fix_col),
        .fix_row (fix_row),
        .fix_val (fix_val)
    );

    rdp_ctrl #(.P(P)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op_sel),
        .fail_mask (fail_mask),
        .fix_ok    (fix_ok),
        .fix_col   (fix_col),
        .fix_row   (fix_row),
        .miss      (miss),
        .fix_we    (fix_we),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

endmodule

// File: rtl/rdp_codec_chk.sv
module rdp_codec_chk #(
    parameter int P = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       op,
    input logic [P:0] fail_mask,
    input logic       busy,
    input logic       done,
    input logic       err
);

    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !err)); // R10

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && done) |=> done); // R10

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && err) |=> err); // R10

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (!op || ($countones(fail_mask) <= 2))) |=> busy); // R3

    AST_TOO_MANY: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && op && ($countones(fail_mask) > 2)) |=> (err && !busy)); // R8

    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done != err)); // R7

endmodule

bind rdp_codec rdp_codec_chk #(.P(P)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .fail_mask (fail_mask),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/rdp_codec_bench.sv
module rdp_codec_bench;
    localparam int P  = 5;
    localparam int W  = 8;
    localparam int NC = P + 1;
    localparam int NR = P - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          op;
    logic [NC-1:0] fail_mask;
    logic          wr_en;
    logic [2:0]    wr_col;
    logic [1:0]    wr_row;
    logic [W-1:0]  wr_data;
    logic [2:0]    rd_col;
    logic [1:0]    rd_row;
    logic [W-1:0]  rd_data;
    logic          busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] ref_m [NC][NR];
    logic [31:0]  seed = 32'h1234_5678;

    always #5 clk = ~clk;

    rdp_codec #(.P(P), .W(W)) u_rdp_codec (
        .clk(clk), .rst(rst), .start(start), .op(op), .fail_mask(fail_mask),
        .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row), .wr_data(wr_data),
        .rd_col(rd_col), .rd_row(rd_row), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic flags(input string tag, input logic b, input logic d, input logic e);
        check({tag, " busy"}, {31'd0, busy}, {31'd0, b});
        check({tag, " done"}, {31'd0, done}, {31'd0, d});
        check({tag, " err"},  {31'd0, err},  {31'd0, e});
    endtask

    task automatic put(input int c, input int r, input logic [W-1:0] v);
        wr_en = 1'b1; wr_col = 3'(c); wr_row = 2'(r); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [W-1:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic calc_parity();
        for (int r = 0; r < NR; r++) begin
            logic [W-1:0] x;
            x = '0;
            for (int c = 0; c < P - 1; c++) x ^= ref_m[c][r];
            ref_m[P-1][r] = x;
        end
        for (int d = 0; d < NR; d++) begin
            logic [W-1:0] x;
            x = '0;
            for (int c = 0; c < P; c++)
                for (int r = 0; r < NR; r++)
                    if ((r + c) % P == d) x ^= ref_m[c][r];
            ref_m[P][d] = x;
        end
    endtask

    // load data words (pattern 0: pseudo-random, 1: walking bit) and junk parity
    task automatic load(input int pat);
        for (int c = 0; c < P - 1; c++)
            for (int r = 0; r < NR; r++) begin
                ref_m[c][r] = (pat == 0) ? next_rand() : W'(8'h01 << ((c + 2 * r) % W));
                put(c, r, ref_m[c][r]);
            end
        for (int c = P - 1; c <= P; c++)
            for (int r = 0; r < NR; r++) put(c, r, next_rand());
        calc_parity();
    endtask

    task automatic smash(input int c);
        for (int r = 0; r < NR; r++) put(c, r, ~ref_m[c][r] ^ 8'h5A);
    endtask

    task automatic verify_all(input string tag);
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++) begin
                rd_col = 3'(c); rd_row = 2'(r);
                #1;
                check($sformatf("%s word c%0d r%0d", tag, c, r), {24'd0, rd_data}, {24'd0, ref_m[c][r]});
            end
    endtask

    // per-cycle flag model: nfix fixes, then done one edge later
    task automatic run_op(input logic o, input logic [NC-1:0] m, input int nfix,
                          input bit want_err, input string tag);
        op = o; fail_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (want_err) begin
            flags(tag, 1'b0, 1'b0, 1'b1);
        end else begin
            for (int k = 0; k <= nfix; k++) begin
                flags($sformatf("%s cyc%0d", tag, k), 1'b1, 1'b0, 1'b0);
                @(negedge clk);
            end
            flags({tag, " end"}, 1'b0, 1'b1, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = 1'b0; fail_mask = '0;
        wr_en = 1'b0; wr_col = '0; wr_row = '0; wr_data = '0;
        rd_col = '0; rd_row = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        flags("R1 reset", 1'b0, 1'b0, 1'b0);
        for (int c = 0; c < NC; c++) for (int r = 0; r < NR; r++) ref_m[c][r] = '0;
        verify_all("R1 reset");

        // R2, R3: encode ignores a full fail_mask
        load(0);
        run_op(1'b0, '1, 2 * NR, 1'b0, "R3 encode");
        verify_all("R2 encode");

        // R10: done held while idle
        repeat (3) @(negedge clk);
        flags("R10 done hold", 1'b0, 1'b1, 1'b0);

        // R4, R6, R7: every single column lost
        for (int c = 0; c < NC; c++) begin
            smash(c);
            run_op(1'b1, NC'(1) << c, NR, 1'b0, $sformatf("R7 single c%0d", c));
            verify_all(c < P - 1 ? $sformatf("R4 single c%0d", c) : $sformatf("R6 single c%0d", c));
        end

        // R5, R6: every pair of columns lost
        for (int a = 0; a < NC; a++)
            for (int b = a + 1; b < NC; b++) begin
                smash(a); smash(b);
                run_op(1'b1, (NC'(1) << a) | (NC'(1) << b), 2 * NR, 1'b0,
                       $sformatf("R7 pair c%0d c%0d", a, b));
                verify_all((b < P - 1) ? $sformatf("R5 pair c%0d c%0d", a, b)
                                       : $sformatf("R6 pair c%0d c%0d", a, b));
            end

        // R7: empty mask finishes after one busy cycle
        run_op(1'b1, '0, 0, 1'b0, "R7 empty");
        verify_all("R7 empty");

        // R8: three lost columns rejected, nothing changes
        run_op(1'b1, 6'b010101, 0, 1'b1, "R8 three");
        verify_all("R8 unchanged");
        repeat (3) @(negedge clk);
        flags("R10 err hold", 1'b0, 1'b0, 1'b1);

        // second pattern: encode, then recover two data columns (clears err, R10)
        load(1);
        run_op(1'b0, '0, 2 * NR, 1'b0, "R10 encode after err");
        verify_all("R2 walking");
        smash(0); smash(1);
        run_op(1'b1, 6'b000011, 2 * NR, 1'b0, "R5 walking");
        verify_all("R5 walking");

        // R9: host write and start during a run are ignored
        smash(0);
        op = 1'b1; fail_mask = 6'b000001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= NR; k++) begin
            if (k == 0) begin
                wr_en = 1'b1; wr_col = 3'd2; wr_row = 2'd0; wr_data = ~ref_m[2][0];
                start = 1'b1; op = 1'b0; fail_mask = 6'b000111;
            end
            if (k == 2) begin
                wr_en = 1'b0; start = 1'b0;
            end
            flags($sformatf("R9 cyc%0d", k), 1'b1, 1'b0, 1'b0);
            @(negedge clk);
        end
        flags("R9 end", 1'b0, 1'b1, 1'b0);
        verify_all("R9 ignored");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule